// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block collects interrupt events from two sources, a DMA group and a bus group, and presents them to software through read-to-clear status registers, per-group enable masks and a summary register. Each group keeps a small queue of pending status words. A status read clears only the word at the head of the queue. The next queued word then becomes visible, so one read does not necessarily empty the register.

Every enabled pending condition is fatal: it raises both the interrupt request and the halt request to the sequencer, and both stay high until software has read the status. A masked condition is still recorded in its status register but raises nothing. The DMA status register also carries a live FIFO-empty bit. Writes to two control registers produce single-cycle strobes that clear or flush the external FIFOs. Taking an interrupt never touches the FIFOs by itself.

The register port is synchronous. A read returns its data on `rdata_o` one cycle later. The defaults are an 8-bit register width (DW) and a queue depth of 4 (DEPTH).

Top module: `intr_stack_ctrl`

## Requirements
- R1: A read of address 1 returns {fifo_empty_i, DMA head[6:0]} on rdata_o one cycle after the read and removes that head word. rdata_o is zero in every cycle that follows a cycle without a read.
- R2: A nonzero dma_ev_i or bus_ev_i is recorded in the group's queue whatever the enable register holds.
- R3: Each cycle with a nonzero event vector adds a new queue word while fewer than 4 words are held. With 4 words held, the event is ORed into the newest word. After a head is removed, the following word becomes the head.
- R4: When a clearing read and a new event fall in the same cycle, the read acts first and the event is still queued.
- R5: Bit 7 of the DMA status read is fifo_empty_i as sampled in the read cycle. It never raises irq_o or halt_o and is not cleared by reading.
- R6: A write to address 7 produces a one-cycle clr_dma_fifo_o pulse when wdata bit 2 is set, and a one-cycle flush_dma_fifo_o pulse when bit 3 is set. A write to address 8 with bit 1 set produces a one-cycle clr_bus_fifo_o pulse. Each pulse occurs in the cycle after the write.
- R7: The enable registers are read/write and reset to zero: address 4 holds the DMA enables (bits 6:0), address 5 holds bus enables 7:0 and address 6 holds bus enables 15:8. A group is pending when its head word ANDed with its enables is nonzero.
- R8: The bus head word is 16 bits wide. Address 2 reads bits 7:0 and clears them, and address 3 reads bits 15:8 and clears them. The word is removed once both halves are zero.
- R9: Address 0 reads bit 0 as DMA pending and bit 1 as bus pending. Unmapped addresses read zero.
- R10: irq_o and halt_o are high whenever either group is pending. They are held until a status read or an enable write removes the pending condition.
- R11: After reset, rdata_o, irq_o, halt_o and all strobes are zero and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_i | input | 1 | Write enable |
| rd_i | input | 1 | Read enable (reads of status registers clear them) |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_i |
| dma_ev_i | input | DW-1 | DMA event conditions, one bit per source |
| bus_ev_i | input | 2*DW | Bus event conditions, one bit per source |
| fifo_empty_i | input | 1 | FIFO-empty status |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Halt request to the sequencer |
| clr_dma_fifo_o | output | 1 | DMA FIFO clear strobe |
| flush_dma_fifo_o | output | 1 | DMA FIFO flush strobe |
| clr_bus_fifo_o | output | 1 | Bus FIFO clear strobe |

## Verification
An event or a clearing read changes the queue at the next rising edge. irq_o and halt_o follow from the queue with no further register, so they reflect the new state in that same cycle. Read data and the FIFO strobes each pass through one register and appear in the cycle after the request. The bench drives inputs and samples outputs on the falling edge. Its behavioural model advances one edge per call, so each compare lines up with exactly these latencies.

// File: rtl/intr_stack_pkg.sv
package intr_stack_pkg;
  typedef enum logic [3:0] {
    A_SUMMARY   = 4'd0,
    A_DMA_STAT  = 4'd1,
    A_BUS_STAT0 = 4'd2,
    A_BUS_STAT1 = 4'd3,
    A_DMA_EN    = 4'd4,
    A_BUS_EN0   = 4'd5,
    A_BUS_EN1   = 4'd6,
    A_DMA_CTL   = 4'd7,
    A_BUS_CTL   = 4'd8
  } reg_addr_e;

  localparam int CLR_DMA_BIT   = 2;
  localparam int FLUSH_DMA_BIT = 3;
  localparam int CLR_BUS_BIT   = 1;
endpackage

// File: rtl/intr_stack.sv
module intr_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] head_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  ent_q [DEPTH];
  logic [W-1:0]  ent_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  head_clr;
  logic          pop;

  always_comb begin
    head_clr = ent_q[0] & ~clr_i;
    pop      = (cnt_q != '0) && (|clr_i) && (head_clr == '0);
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    ent_d[0] = head_clr;
    cnt_d    = cnt_q;
    // clearing read takes effect before same-cycle events
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
      ent_d[DEPTH-1] = '0;
      cnt_d = cnt_q - 1'b1;
    end
    if (|ev_i) begin
      if (cnt_d == CW'(DEPTH)) begin
        ent_d[DEPTH-1] = ent_d[DEPTH-1] | ev_i;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (cnt_d == CW'(i)) ent_d[i] = ev_i;
        cnt_d = cnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign head_o = ent_q[0];

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R3
  AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> (cnt_q != '0)); // R4
  AST_HEAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (ent_q[0] != '0)); // R3
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_stack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DMA_W = DW - 1,
  parameter int BUS_W = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DMA_W-1:0] dma_head_i,
  input  logic [BUS_W-1:0] bus_head_i,
  input  logic             fifo_empty_i,
  input  logic             dma_pend_i,
  input  logic             bus_pend_i,
  output logic [DMA_W-1:0] dma_en_o,
  output logic [BUS_W-1:0] bus_en_o,
  output logic [DMA_W-1:0] dma_clr_o,
  output logic [BUS_W-1:0] bus_clr_o,
  output logic [DW-1:0]    rdata_o,
  output logic             clr_dma_fifo_o,
  output logic             flush_dma_fifo_o,
  output logic             clr_bus_fifo_o
);
  logic [DMA_W-1:0] dma_en_q;
  logic [BUS_W-1:0] bus_en_q;
  logic [DW-1:0]    rdata_q, rd_mux;
  logic             clr_dma_q, flush_dma_q, clr_bus_q;

  always_comb begin
    unique case (addr_i)
      A_SUMMARY:   rd_mux = {{(DW-2){1'b0}}, bus_pend_i, dma_pend_i};
      A_DMA_STAT:  rd_mux = {fifo_empty_i, dma_head_i};
      A_BUS_STAT0: rd_mux = bus_head_i[DW-1:0];
      A_BUS_STAT1: rd_mux = bus_head_i[BUS_W-1:DW];
      A_DMA_EN:    rd_mux = {1'b0, dma_en_q};
      A_BUS_EN0:   rd_mux = bus_en_q[DW-1:0];
      A_BUS_EN1:   rd_mux = bus_en_q[BUS_W-1:DW];
      default:     rd_mux = '0;
    endcase
  end

  assign dma_clr_o = (rd_i && addr_i == A_DMA_STAT) ? '1 : '0;
  always_comb begin
    bus_clr_o = '0;
    if (rd_i && addr_i == A_BUS_STAT0) bus_clr_o[DW-1:0]     = '1;
    if (rd_i && addr_i == A_BUS_STAT1) bus_clr_o[BUS_W-1:DW] = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_en_q    <= '0;
      bus_en_q    <= '0;
      rdata_q     <= '0;
      clr_dma_q   <= 1'b0;
      flush_dma_q <= 1'b0;
      clr_bus_q   <= 1'b0;
    end else begin
      rdata_q     <= rd_i ? rd_mux : '0;
      clr_dma_q   <= wr_i && addr_i == A_DMA_CTL && wdata_i[CLR_DMA_BIT];
      flush_dma_q <= wr_i && addr_i == A_DMA_CTL && wdata_i[FLUSH_DMA_BIT];
      clr_bus_q   <= wr_i && addr_i == A_BUS_CTL && wdata_i[CLR_BUS_BIT];
      if (wr_i && addr_i == A_DMA_EN)  dma_en_q            <= wdata_i[DMA_W-1:0];
      if (wr_i && addr_i == A_BUS_EN0) bus_en_q[DW-1:0]     <= wdata_i;
      if (wr_i && addr_i == A_BUS_EN1) bus_en_q[BUS_W-1:DW] <= wdata_i;
    end
  end

  assign dma_en_o         = dma_en_q;
  assign bus_en_o         = bus_en_q;
  assign rdata_o          = rdata_q;
  assign clr_dma_fifo_o   = clr_dma_q;
  assign flush_dma_fifo_o = flush_dma_q;
  assign clr_bus_fifo_o   = clr_bus_q;

  AST_FIFO_BIT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == A_DMA_STAT) |-> rdata_o[DW-1] == $past(fifo_empty_i)); // R5
endmodule

// File: rtl/intr_stack_ctrl.sv
module intr_stack_ctrl
  import intr_stack_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-2:0] dma_ev_i,
  input  logic [2*DW-1:0] bus_ev_i,
  input  logic          fifo_empty_i,
  output logic          irq_o,
  output logic          halt_o,
  output logic          clr_dma_fifo_o,
  output logic          flush_dma_fifo_o,
  output logic          clr_bus_fifo_o
);
  localparam int DMA_W = DW - 1;
  localparam int BUS_W = 2 * DW;

  logic [DMA_W-1:0] dma_head, dma_en, dma_clr;
  logic [BUS_W-1:0] bus_head, bus_en, bus_clr;
  logic             dma_pend, bus_pend;

  intr_stack #(.W(DMA_W), .DEPTH(DEPTH)) u_dma_stack (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ev_i  (dma_ev_i), .clr_i(dma_clr), .head_o(dma_head)
  );

  intr_stack #(.W(BUS_W), .DEPTH(DEPTH)) u_bus_stack (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .ev_i  (bus_ev_i), .clr_i(bus_clr), .head_o(bus_head)
  );

  intr_regs #(.DW(DW), .DMA_W(DMA_W), .BUS_W(BUS_W)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .addr_i          (addr_i),
    .wr_i            (wr_i),
    .rd_i            (rd_i),
    .wdata_i         (wdata_i),
    .dma_head_i      (dma_head),
    .bus_head_i      (bus_head),
    .fifo_empty_i    (fifo_empty_i),
    .dma_pend_i      (dma_pend),
    .bus_pend_i      (bus_pend),
    .dma_en_o        (dma_en),
    .bus_en_o        (bus_en),
    .dma_clr_o       (dma_clr),
    .bus_clr_o       (bus_clr),
    .rdata_o         (rdata_o),
    .clr_dma_fifo_o  (clr_dma_fifo_o),
    .flush_dma_fifo_o(flush_dma_fifo_o),
    .clr_bus_fifo_o  (clr_bus_fifo_o)
  );

  // enabled pending conditions are fatal in both groups
  assign dma_pend = |(dma_head & dma_en);
  assign bus_pend = |(bus_head & bus_en);
  assign irq_o    = dma_pend | bus_pend;
  assign halt_o   = dma_pend | bus_pend;

  AST_DMA_LATCH_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dma_ev_i) |=> (dma_head != '0)); // R2
  AST_BUS_LATCH_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bus_ev_i) |=> (bus_head != '0)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !rd_i && !wr_i) |=> halt_o); // R10
endmodule

// File: tb/tb_intr_stack_ctrl.sv
module tb_intr_stack_ctrl;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [6:0]  dma_ev = '0;
  logic [15:0] bus_ev = '0;
  logic        fe = 1'b0;
  logic        irq, halt, clr_dma, flush_dma, clr_bus;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  intr_stack_ctrl #(.DW(8), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .dma_ev_i(dma_ev), .bus_ev_i(bus_ev),
    .fifo_empty_i(fe), .irq_o(irq), .halt_o(halt), .clr_dma_fifo_o(clr_dma),
    .flush_dma_fifo_o(flush_dma), .clr_bus_fifo_o(clr_bus)
  );

  // behavioural reference model
  logic [6:0]  dq[$];
  logic [15:0] bq[$];
  logic [6:0]  den = '0;
  logic [15:0] ben = '0;
  logic [7:0]  e_rdata = '0;
  logic        e_cd = 0, e_fl = 0, e_cb = 0;
  string       rd_tag = "R1";

  function automatic logic m_dpend();
    return dq.size() > 0 && |(dq[0] & den);
  endfunction
  function automatic logic m_bpend();
    return bq.size() > 0 && |(bq[0] & ben);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R10 irq", irq, m_dpend() | m_bpend());
    chk("R10 halt", halt, m_dpend() | m_bpend());
    chk(rd_tag, rdata, e_rdata);
    chk("R6 clr_dma", clr_dma, e_cd);
    chk("R6 flush_dma", flush_dma, e_fl);
    chk("R6 clr_bus", clr_bus, e_cb);
  endtask

  task automatic step_model(int a, bit w, bit r, logic [7:0] wd,
                            logic [6:0] de, logic [15:0] be, bit f);
    logic [6:0]  dh;
    logic [15:0] bh, h;
    dh = dq.size() ? dq[0] : '0;
    bh = bq.size() ? bq[0] : '0;
    e_rdata = '0;
    if (r) begin
      case (a)
        0: begin e_rdata = {6'b0, m_bpend(), m_dpend()}; rd_tag = "R9"; end
        1: begin e_rdata = {f, dh}; rd_tag = "R1 R5"; end
        2: begin e_rdata = bh[7:0]; rd_tag = "R8"; end
        3: begin e_rdata = bh[15:8]; rd_tag = "R8"; end
        4: begin e_rdata = {1'b0, den}; rd_tag = "R7"; end
        5: begin e_rdata = ben[7:0]; rd_tag = "R7"; end
        6: begin e_rdata = ben[15:8]; rd_tag = "R7"; end
        default: rd_tag = "R9";
      endcase
    end else rd_tag = "R1";
    e_cd = w && a == 7 && wd[2];
    e_fl = w && a == 7 && wd[3];
    e_cb = w && a == 8 && wd[1];
    if (w && a == 4) den = wd[6:0];
    if (w && a == 5) ben[7:0] = wd;
    if (w && a == 6) ben[15:8] = wd;
    if (r && a == 1 && dq.size()) void'(dq.pop_front());
    if (r && (a == 2 || a == 3) && bq.size()) begin
      h = bq[0] & ((a == 2) ? 16'hff00 : 16'h00ff);
      if (h == 0) void'(bq.pop_front()); else bq[0] = h;
    end
    if (de != 0) begin
      if (dq.size() < DEPTH) dq.push_back(de); else dq[DEPTH-1] = dq[DEPTH-1] | de;
    end
    if (be != 0) begin
      if (bq.size() < DEPTH) bq.push_back(be); else bq[DEPTH-1] = bq[DEPTH-1] | be;
    end
  endtask

  // one clock: compare at falling edge, drive, advance model across next rising edge
  task automatic cyc(int a = 0, bit w = 0, bit r = 0, logic [7:0] wd = 0,
                     logic [6:0] de = 0, logic [15:0] be = 0, bit f = 0);
    @(negedge clk);
    compare();
    addr = 4'(a); wr = w; rd = r; wdata = wd; dma_ev = de; bus_ev = be; fe = f;
    step_model(a, w, r, wd, de, be, f);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rdata", rdata, 0);
    chk("R11 irq", irq, 0);
    chk("R11 halt", halt, 0);
    chk("R11 strobes", {clr_dma, flush_dma, clr_bus}, 0);
    rst_ni = 1'b1;

    // R2: masked event is recorded but raises nothing
    cyc(.de(7'h05));
    cyc();
    chk("R2 masked irq", irq, 0);
    cyc(.a(1), .r(1), .f(1));
    cyc();
    chk("R2 status recorded", rdata, 8'h85);

    // R7: enables
    cyc(.a(4), .w(1), .wd(8'h7f));
    cyc(.a(5), .w(1), .wd(8'hff));
    cyc(.a(6), .w(1), .wd(8'hff));
    cyc(.a(4), .r(1));
    cyc();
    chk("R7 enable readback", rdata, 8'h7f);

    // R3: stacking and overflow merge
    cyc(.de(7'h01)); cyc(.de(7'h02)); cyc(.de(7'h04)); cyc(.de(7'h08)); cyc(.de(7'h10));
    cyc();
    chk("R10 irq on pending", irq, 1);
    chk("R10 halt on pending", halt, 1);
    cyc(.a(1), .r(1)); cyc(); chk("R3 first", rdata, 8'h01);
    chk("R3 still pending", irq, 1);
    cyc(.a(1), .r(1)); cyc(); chk("R3 second", rdata, 8'h02);
    cyc(.a(1), .r(1)); cyc(); chk("R3 third", rdata, 8'h04);
    cyc(.a(1), .r(1)); cyc(); chk("R3 merged", rdata, 8'h18);
    chk("R10 released", irq, 0);

    // R4: event in same cycle as clearing read
    cyc(.de(7'h01));
    cyc(.a(1), .r(1), .de(7'h02));
    cyc(); chk("R4 head read", rdata, 8'h01);
    chk("R4 event kept pending", irq, 1);
    cyc(.a(1), .r(1)); cyc(); chk("R4 kept event", rdata, 8'h02);

    // R8: bus halves
    cyc(.be(16'h0201));
    cyc(.a(2), .r(1)); cyc(); chk("R8 low half", rdata, 8'h01);
    chk("R8 high half pending", irq, 1);
    cyc(.a(3), .r(1)); cyc(); chk("R8 high half", rdata, 8'h02);
    chk("R8 word removed", irq, 0);

    // R9: summary
    cyc(.be(16'h8000));
    cyc(.a(0), .r(1)); cyc(); chk("R9 summary", rdata, 8'h02);
    cyc(.a(3), .r(1)); cyc();
    cyc(.a(9), .r(1)); cyc(); chk("R9 unmapped", rdata, 8'h00);

    // R6: strobes
    cyc(.a(7), .w(1), .wd(8'h0c));
    cyc(); chk("R6 clr_dma", clr_dma, 1); chk("R6 flush_dma", flush_dma, 1);
    cyc(); chk("R6 pulse width", clr_dma, 0);
    cyc(.a(8), .w(1), .wd(8'h02));
    cyc(); chk("R6 clr_bus", clr_bus, 1);

    // R5: fifo-empty bit
    cyc(.f(1));
    chk("R5 no irq from fifo bit", irq, 0);
    cyc(.a(1), .r(1), .f(1)); cyc(.f(1)); chk("R5 read", rdata, 8'h80);
    cyc(.a(1), .r(1), .f(1)); cyc(.f(1)); chk("R5 not cleared", rdata, 8'h80);

    // random phase, model compared on every clock
    for (int k = 0; k < 4000; k++) begin
      int op;
      int a;
      logic [7:0]  wd;
      logic [6:0]  de;
      logic [15:0] be;
      op = $urandom % 8;
      a  = $urandom % 10;
      wd = 8'($urandom);
      de = ($urandom % 3 == 0) ? 7'($urandom) : 7'h0;
      be = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0;
      if (op < 3)      cyc(.de(de), .be(be), .f(k[4]));
      else if (op < 6) cyc(.a(a % 4), .r(1), .de(de), .be(be), .f(k[4]));
      else if (op < 7) cyc(.a(a), .r(1), .de(de), .be(be), .f(k[5]));
      else             cyc(.a(a), .w(1), .wd(wd), .de(de), .be(be), .f(k[4]));
    end
    cyc();
    cyc();
    finish_run();
  end
endmodule